// File: doc/BRIEF.md
# Colour Channel Selection Controller

This block picks the active colour for a scanning front end that delivers its colours one line at a time. It drives two 2-bit selects. One steers the analog input multiplexer. The other picks the offset and gain register bank. It also drives one power enable for each processing block.

Either select can be taken straight from a register field. Either can also step through red, green and blue on pulses that arrive on an asynchronous auto-cycle pin. The input multiplexer can be pinned to a forced register value while the offset/gain bank keeps cycling. A strobe from a write to the cycle-reset register sends the cycled position back to red.

The power enables come from three sources: a global enable bit, a selective-mode bit and a per-block disable vector. In line-by-line mode the green and blue processing paths are switched off, so all work passes through the red path. Register values arrive on plain input ports, and the block keeps no configuration of its own.

Top module: `colsel_ctrl`

## Requirements
- R1: Colour codes are red = 2'b00, green = 2'b01 and blue = 2'b10. A register select value of 2'b11 is taken as red. While reset is asserted, and after it is released, both selects read red.
- R2: The auto-cycle pin passes through a two-flop synchronizer. A rise seen at rising edge k changes the cycled position after rising edge k+2, and the position is unchanged after edge k+1. A pulse held high for many cycles advances the position once.
- R3: When auto-cycling is enabled, each auto-cycle pulse advances the cycled position red -> green -> blue -> red.
- R4: A cycle-reset strobe sampled at a rising edge sets the cycled position to red at that edge. If a pulse edge is acted on in the same cycle, the strobe wins and the pulse is lost.
- R5: While auto-cycling is disabled, auto-cycle pulses leave the cycled position unchanged. This is seen at the selects once auto-cycling is enabled again.
- R6: With force off and auto off, both selects follow the internal select field.
- R7: With force off and auto on, both selects show the cycled position.
- R8: With force on and auto off, the input select follows the forced field and the offset/gain select follows the internal field.
- R9: With force on and auto on, the input select follows the forced field and the offset/gain select shows the cycled position.
- R10: Per block, power is off when the enable bit and the selective bit are both 0, on when the enable bit is 1 and the selective bit is 0, and equal to the inverse of that block's disable bit when the selective bit is 1. Bit 0 is the red path, bit 1 the green path, bit 2 the blue path and bit 3 the converter.
- R11: With line-by-line mode set, power bits 1 and 2 are 0 whatever the other power inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acyc_i | input | 1 | Asynchronous auto-cycle pulse |
| force_en_i | input | 1 | Input mux taken from forced field |
| auto_en_i | input | 1 | Auto-cycling enabled |
| force_sel_i | input | 2 | Forced input-mux colour |
| int_sel_i | input | 2 | Internal colour select |
| cyc_rst_i | input | 1 | Strobe from a write to the cycle-reset register |
| lbl_i | input | 1 | Line-by-line mode |
| pwr_en_i | input | 1 | Global power enable |
| pwr_sel_i | input | 1 | Selective power-down mode |
| blk_dis_i | input | 4 | Per-block disable bits (selective mode) |
| in_sel_o | output | 2 | Input multiplexer colour |
| og_sel_o | output | 2 | Offset/gain register bank colour |
| blk_pwr_o | output | 4 | Per-block power enables |

## Verification
Two functions can act on the cycled position in the same clock: a synchronized pulse edge and a cycle-reset strobe. The bench first advances the position away from red. It then raises the pulse pin and asserts the strobe two edges later, so that the strobe lands in the very cycle the detected edge is acted on. The position must read red afterwards and must stay red, which shows that the edge was consumed and not deferred. Random runs mix pulses, strobes, mode changes and power settings, and every output is compared against a bench model after each step.

// File: rtl/colsel_pkg.sv
package colsel_pkg;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    COL_RED   = 2'b00,
    COL_GREEN = 2'b01,
    COL_BLUE  = 2'b10
  } colour_e;

  // 2'b11 is not a colour; map it onto red
  function automatic colour_e col_norm(input logic [SEL_W-1:0] v);
    case (v)
      2'b01:   return COL_GREEN;
      2'b10:   return COL_BLUE;
      default: return COL_RED;
    endcase
  endfunction

  function automatic colour_e col_next(input colour_e c);
    case (c)
      COL_RED:   return COL_GREEN;
      COL_GREEN: return COL_BLUE;
      default:   return COL_RED;
    endcase
  endfunction
endpackage

// File: rtl/colsel_sync_edge.sv
module colsel_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  localparam int LAST = STAGES;

  logic [LAST:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[LAST-1:0], async_i};
  end

  assign rise_o = sh_q[LAST-1] & ~sh_q[LAST];

  // R2: a long pulse yields a single-cycle edge
  a_r2_one_shot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/colsel_cycler.sv
module colsel_cycler
  import colsel_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    adv_i,
  input  logic    clr_i,
  output colour_e pos_o
);
  colour_e pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pos_q <= COL_RED;
    else if (clr_i) pos_q <= COL_RED;
    else if (adv_i) pos_q <= col_next(pos_q);
  end

  assign pos_o = pos_q;

  a_r1_legal_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q != 2'b11);
  a_r3_step_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !clr_i |=> pos_q == col_next($past(pos_q)));
  a_r4_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> pos_q == COL_RED);
  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i && !clr_i |=> $stable(pos_q));
endmodule

// File: rtl/colsel_power.sv
module colsel_power #(
  parameter int NUM_BLK = 4,
  parameter int GRN_IDX = 1,
  parameter int BLU_IDX = 2
) (
  input  logic               lbl_i,
  input  logic               pwr_en_i,
  input  logic               pwr_sel_i,
  input  logic [NUM_BLK-1:0] blk_dis_i,
  output logic [NUM_BLK-1:0] blk_pwr_o
);
  for (genvar i = 0; i < NUM_BLK; i++) begin : g_blk
    logic base;
    assign base = pwr_sel_i ? ~blk_dis_i[i] : pwr_en_i;
    if (i == GRN_IDX || i == BLU_IDX) begin : g_colour
      assign blk_pwr_o[i] = base & ~lbl_i;
    end else begin : g_plain
      assign blk_pwr_o[i] = base;
    end
  end
endmodule

// File: rtl/colsel_ctrl.sv
module colsel_ctrl
  import colsel_pkg::*;
#(
  parameter int NUM_BLK     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               acyc_i,
  input  logic               force_en_i,
  input  logic               auto_en_i,
  input  logic [SEL_W-1:0]   force_sel_i,
  input  logic [SEL_W-1:0]   int_sel_i,
  input  logic               cyc_rst_i,
  input  logic               lbl_i,
  input  logic               pwr_en_i,
  input  logic               pwr_sel_i,
  input  logic [NUM_BLK-1:0] blk_dis_i,
  output logic [SEL_W-1:0]   in_sel_o,
  output logic [SEL_W-1:0]   og_sel_o,
  output logic [NUM_BLK-1:0] blk_pwr_o
);
  localparam int GRN_IDX = 1;
  localparam int BLU_IDX = 2;

  logic    rise;
  colour_e pos;
  colour_e int_col, frc_col;

  colsel_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(acyc_i),
    .rise_o (rise)
  );

  // pulses only count while auto-cycling is on
  colsel_cycler u_cyc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (rise & auto_en_i),
    .clr_i (cyc_rst_i),
    .pos_o (pos)
  );

  colsel_power #(.NUM_BLK(NUM_BLK), .GRN_IDX(GRN_IDX), .BLU_IDX(BLU_IDX)) u_pwr (
    .lbl_i    (lbl_i),
    .pwr_en_i (pwr_en_i),
    .pwr_sel_i(pwr_sel_i),
    .blk_dis_i(blk_dis_i),
    .blk_pwr_o(blk_pwr_o)
  );

  assign int_col = col_norm(int_sel_i);
  assign frc_col = col_norm(force_sel_i);

  always_comb begin
    og_sel_o = auto_en_i  ? pos     : int_col;
    in_sel_o = force_en_i ? frc_col : og_sel_o;
  end

  a_r6_common_int: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !force_en_i && !auto_en_i |-> in_sel_o == og_sel_o);
  a_r9_split: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_en_i && auto_en_i |-> og_sel_o == pos && in_sel_o != 2'b11);
  a_r10_all_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_en_i && !pwr_sel_i |-> blk_pwr_o == '0);
  a_r11_lbl_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lbl_i |-> !blk_pwr_o[GRN_IDX] && !blk_pwr_o[BLU_IDX]);
endmodule

// File: tb/colsel_ctrl_bench.sv
module colsel_ctrl_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       acyc = 0, force_en = 0, auto_en = 0, cyc_rst = 0;
  logic [1:0] force_sel = 0, int_sel = 0;
  logic       lbl = 0, pwr_en = 1, pwr_sel = 0;
  logic [3:0] blk_dis = 0;
  logic [1:0] in_sel, og_sel;
  logic [3:0] blk_pwr;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [1:0] exp_pos = 0;

  always #5 clk = ~clk;

  colsel_ctrl u_colsel_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .acyc_i(acyc), .force_en_i(force_en),
    .auto_en_i(auto_en), .force_sel_i(force_sel), .int_sel_i(int_sel),
    .cyc_rst_i(cyc_rst), .lbl_i(lbl), .pwr_en_i(pwr_en), .pwr_sel_i(pwr_sel),
    .blk_dis_i(blk_dis), .in_sel_o(in_sel), .og_sel_o(og_sel), .blk_pwr_o(blk_pwr)
  );

  function automatic logic [1:0] norm(input logic [1:0] v);
    return (v == 2'b11) ? 2'b00 : v;
  endfunction
  function automatic logic [1:0] nxt(input logic [1:0] v);
    return (v == 2'b10) ? 2'b00 : v + 2'b01;
  endfunction
  function automatic logic [1:0] exp_og();
    return auto_en ? exp_pos : norm(int_sel);
  endfunction
  function automatic logic [1:0] exp_in();
    return force_en ? norm(force_sel) : exp_og();
  endfunction
  function automatic logic [3:0] exp_pwr();
    logic [3:0] p;
    p = pwr_sel ? ~blk_dis : {4{pwr_en}};
    if (lbl) p[2:1] = 2'b00;
    return p;
  endfunction

  task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " in_sel"}, {2'b0, in_sel}, {2'b0, exp_in()});
    chk({tag, " og_sel"}, {2'b0, og_sel}, {2'b0, exp_og()});
    chk({tag, " pwr"}, blk_pwr, exp_pwr());
  endtask

  // pulse held for 'hold' cycles, then settle
  task automatic pulse(input int hold);
    @(negedge clk) acyc = 1;
    repeat (hold) @(negedge clk);
    acyc = 0;
    repeat (3) @(negedge clk);
    if (auto_en) exp_pos = nxt(exp_pos);
  endtask

  task automatic strobe();
    @(negedge clk) cyc_rst = 1;
    @(negedge clk) cyc_rst = 0;
    exp_pos = 2'b00;
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_up();
    end
  end

  initial begin
    void'($urandom(32'd20231));
    auto_en = 1;
    repeat (3) @(negedge clk);
    chk("R1 reset in", {2'b0, in_sel}, 4'h0);
    chk("R1 reset og", {2'b0, og_sel}, 4'h0);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    chk_all("R1 after reset");

    // R2 latency: raise at negedge, seen at edge k
    @(negedge clk) acyc = 1;
    @(negedge clk);
    @(negedge clk);
    chk("R2 k+1 unchanged", {2'b0, og_sel}, 4'h0);
    @(negedge clk);
    chk("R2 k+2 advanced", {2'b0, og_sel}, 4'h1);
    repeat (20) @(negedge clk);
    chk("R2 long pulse once", {2'b0, og_sel}, 4'h1);
    acyc = 0;
    exp_pos = 2'b01;
    repeat (3) @(negedge clk);

    // R3 order and wrap
    pulse(1); chk("R3 green->blue", {2'b0, og_sel}, 4'h2);
    pulse(2); chk("R3 blue->red", {2'b0, og_sel}, 4'h0);
    pulse(1); chk("R3 red->green", {2'b0, og_sel}, 4'h1);

    // R4 strobe collides with the detected edge
    @(negedge clk) acyc = 1;
    @(negedge clk);
    @(negedge clk) cyc_rst = 1;
    @(negedge clk) cyc_rst = 0; acyc = 0;
    chk("R4 strobe wins", {2'b0, og_sel}, 4'h0);
    repeat (4) @(negedge clk);
    chk("R4 edge consumed", {2'b0, og_sel}, 4'h0);
    exp_pos = 0;

    // R5 pulses ignored with auto off
    pulse(1);
    auto_en = 0; int_sel = 2'b10;
    pulse(1); pulse(3);
    chk("R6 int select", {2'b0, og_sel}, 4'h2);
    auto_en = 1;
    #1 chk("R5 ignored", {2'b0, og_sel}, 4'h1);

    // R1 code 11 and R8 / R9
    auto_en = 0; force_en = 1; force_sel = 2'b11; int_sel = 2'b11;
    #1 chk_all("R1 R8 code 11");
    force_sel = 2'b10; int_sel = 2'b01;
    #1 chk_all("R8 split static");
    auto_en = 1;
    #1 chk_all("R9 split cycled");
    force_en = 0;
    #1 chk_all("R7 common cycled");

    // R10 / R11 table
    pwr_en = 0; pwr_sel = 0; lbl = 0;
    #1 chk("R10 all off", blk_pwr, 4'h0);
    pwr_en = 1;
    #1 chk("R10 all on", blk_pwr, 4'hF);
    pwr_sel = 1; blk_dis = 4'b1010;
    #1 chk("R10 selective", blk_pwr, 4'b0101);
    pwr_sel = 0; lbl = 1;
    #1 chk("R11 lbl gate", blk_pwr, 4'b1001);

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 3);
      case (op)
        0: begin
          @(negedge clk);
          force_en = $urandom; auto_en = $urandom;
          force_sel = $urandom; int_sel = $urandom;
        end
        1: pulse($urandom_range(1, 6));
        2: strobe();
        default: begin
          @(negedge clk);
          lbl = $urandom; pwr_en = $urandom; pwr_sel = $urandom; blk_dis = $urandom;
        end
      endcase
      #1 chk_all("R3 R4 R6 R7 R8 R9 R10 R11 random");
    end
    finish_up();
  end
endmodule